// File: doc/BRIEF.md
# Memory Protection Access Gate

This block guards a small program memory and a data EEPROM array that sit behind one request channel. Each request is tagged as coming either from the internal processor or from the external programming port. Two 14-bit configuration words, loaded from a shadow copy at reset, decide which of these requests may reach the arrays. An external read that is refused returns zero. Self-writes from the processor are confined to the part of program memory that the write-protect field leaves open.

A bulk erase command sets every word of both arrays to the erased all-ones value, at one address per cycle. Only after the last word has been written does it install a new pair of configuration words. Protection therefore cannot be lifted while old contents remain. While the erase runs, the block reports busy and refuses every access.

Top module: `prot_access_gate`

## Requirements
- R1: In the first cycles after reset, `cfg_w1_o` equals the shadow word 1, `busy_o`, `rsp_valid_o` and `viol_o` are 0, and an external read issued under that configuration is judged by it.
- R2: A processor read of program memory (`req_ext_i`=0, `req_ee_i`=0) is never refused, whatever the configuration. It returns the stored word with `rsp_valid_o` one cycle after the request.
- R3: Word 1 bit 7 is the active-low program protect bit. When it is 0, an external read of program memory returns zero and an external write is dropped. When it is 1, both are carried out.
- R4: Word 1 bit 8 is the active-low EEPROM protect bit. When it is 0, external EEPROM reads return zero and external writes are dropped. Processor EEPROM reads and writes are always carried out.
- R5: Word 2 bits 1:0 limit processor writes to program memory. Code 11 locks nothing. Code 10 locks the lowest 1/16 of the array (addresses 0 to 31 at the default depth of 512). Code 01 locks the lower half (0 to 255). Code 00 locks every address. External writes are not subject to this field.
- R6: Every refused read or write raises `viol_o` for exactly the cycle in which the response to that request appears, one cycle after the request. Accepted requests leave it at 0.
- R7: An erase request raises `busy_o` for exactly 2^PM_AW cycles. After that, every program word reads 3FFFh and every EEPROM byte reads FFh.
- R8: Any request sampled while `busy_o` is 1 is refused. A read returns zero, a write is dropped, and `viol_o` pulses.
- R9: The configuration outputs keep their old values for the whole erase. The new words supplied with the erase request appear in the cycle in which `busy_o` falls.
- R10: Word 2 bit 13 (the low-voltage programming enable) is installed as 1 by an erase whose request came with `lv_entry_i`=1, whatever value was supplied. Otherwise it is installed as supplied.
- R11: Word 2 bits 11, 7, 6, 5, 4, 3 and 2 always read as 1 on `cfg_w2_o` (OR mask 08FCh).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shadow_w1_i | input | 14 | Stored configuration word 1, loaded at reset |
| shadow_w2_i | input | 14 | Stored configuration word 2, loaded at reset |
| req_valid_i | input | 1 | Access request present |
| req_ext_i | input | 1 | 1: external programming port, 0: processor |
| req_write_i | input | 1 | 1: write, 0: read |
| req_ee_i | input | 1 | 1: EEPROM array, 0: program memory |
| req_addr_i | input | PM_AW | Word address (low EE_AW bits used for EEPROM) |
| req_wdata_i | input | PM_DW | Write data (low EE_DW bits used for EEPROM) |
| erase_req_i | input | 1 | Start bulk erase (ignored while busy) |
| erase_w1_i | input | 14 | Word 1 to install after the erase |
| erase_w2_i | input | 14 | Word 2 to install after the erase |
| lv_entry_i | input | 1 | Session was entered through the low-voltage path |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_rdata_o | output | PM_DW | Read data (zero when refused) |
| viol_o | output | 1 | One-cycle pulse for a refused request |
| busy_o | output | 1 | Bulk erase in progress |
| cfg_w1_o | output | 14 | Active configuration word 1 |
| cfg_w2_o | output | 14 | Active configuration word 2, unimplemented bits as 1 |

## Verification
The assertions take for granted that each input is held steady from shortly after one rising edge until after the next. They also assume that a request never reads and writes the same address in one cycle, since the arrays return the old word in that case. The stimulus drives every input one nanosecond after an edge, and requests reach an address only after any write to it has completed. The assertions also assume that an erase request is not raised in the same cycle as an access. The bench only issues erases on idle cycles, and it probes the refusal of requests only once `busy_o` is already high.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  localparam int CFG_W = 14;
  localparam int CP_BIT  = 7;
  localparam int CPD_BIT = 8;
  localparam int LVP_BIT = 13;
  localparam logic [CFG_W-1:0] W2_ONES_MASK = 14'h08FC;
  localparam logic [CFG_W-1:0] LVP_MASK     = 14'h2000;

  typedef enum logic [1:0] {
    WP_ALL  = 2'b00,
    WP_HALF = 2'b01,
    WP_BOOT = 2'b10,
    WP_NONE = 2'b11
  } wp_mode_e;
endpackage

// File: rtl/mpg_sram.sv
module mpg_sram #(
  parameter int AW = 9,
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/mpg_erase_seq.sv
module mpg_erase_seq #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          busy_o,
  output logic [AW-1:0] addr_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = '1;

  logic [AW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign addr_o = cnt_q;
  assign done_o = busy_q && (cnt_q == LAST);

  AST_ERASE_SPAN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(addr_o) == LAST); // R7
  AST_ERASE_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> addr_o == '0); // R7
endmodule

// File: rtl/mpg_policy.sv
module mpg_policy
  import mpg_pkg::*;
#(
  parameter int PM_AW = 9
) (
  input  logic             busy_i,
  input  logic             ext_i,
  input  logic             wr_i,
  input  logic             ee_i,
  input  logic [PM_AW-1:0] addr_i,
  input  logic             cp_n_i,
  input  logic             cpd_n_i,
  input  wp_mode_e         wp_i,
  output logic             allow_o
);
  localparam int DEPTH    = 1 << PM_AW;
  localparam int BOOT_LIM = DEPTH / 16;
  localparam int HALF_LIM = DEPTH / 2;

  always_comb begin
    if (busy_i)      allow_o = 1'b0;
    else if (ee_i)   allow_o = !ext_i || cpd_n_i;
    else if (ext_i)  allow_o = cp_n_i;
    else if (!wr_i)  allow_o = 1'b1;
    else begin
      unique case (wp_i)
        WP_NONE: allow_o = 1'b1;
        WP_BOOT: allow_o = addr_i >= PM_AW'(BOOT_LIM);
        WP_HALF: allow_o = addr_i >= PM_AW'(HALF_LIM);
        default: allow_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/prot_access_gate.sv
module prot_access_gate
  import mpg_pkg::*;
#(
  parameter int PM_AW = 9,
  parameter int PM_DW = 14,
  parameter int EE_AW = 6,
  parameter int EE_DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [13:0]      shadow_w1_i,
  input  logic [13:0]      shadow_w2_i,
  input  logic             req_valid_i,
  input  logic             req_ext_i,
  input  logic             req_write_i,
  input  logic             req_ee_i,
  input  logic [PM_AW-1:0] req_addr_i,
  input  logic [PM_DW-1:0] req_wdata_i,
  input  logic             erase_req_i,
  input  logic [13:0]      erase_w1_i,
  input  logic [13:0]      erase_w2_i,
  input  logic             lv_entry_i,
  output logic             rsp_valid_o,
  output logic [PM_DW-1:0] rsp_rdata_o,
  output logic             viol_o,
  output logic             busy_o,
  output logic [13:0]      cfg_w1_o,
  output logic [13:0]      cfg_w2_o
);
  logic [CFG_W-1:0] cfg_w1_q, cfg_w2_q, pend_w1_q, pend_w2_q;
  logic             allow;
  logic [PM_AW-1:0] seq_addr;
  logic             seq_done, ee_in_range;
  logic             pm_we, ee_we;
  logic [PM_AW-1:0] pm_waddr;
  logic [EE_AW-1:0] ee_waddr;
  logic [PM_DW-1:0] pm_wdata, pm_q;
  logic [EE_DW-1:0] ee_wdata, ee_q;
  logic             rsp_valid_q, viol_q, mask_q, sel_ee_q;

  mpg_erase_seq #(.AW(PM_AW)) seq_i (
    .clk(clk), .rst(rst), .start_i(erase_req_i), .busy_o(busy_o),
    .addr_o(seq_addr), .done_o(seq_done)
  );

  mpg_policy #(.PM_AW(PM_AW)) pol_i (
    .busy_i(busy_o), .ext_i(req_ext_i), .wr_i(req_write_i), .ee_i(req_ee_i),
    .addr_i(req_addr_i), .cp_n_i(cfg_w1_q[CP_BIT]), .cpd_n_i(cfg_w1_q[CPD_BIT]),
    .wp_i(wp_mode_e'(cfg_w2_q[1:0])), .allow_o(allow)
  );

  assign ee_in_range = (seq_addr >> EE_AW) == '0;

  always_comb begin
    if (busy_o) begin
      pm_we    = 1'b1;
      pm_waddr = seq_addr;
      pm_wdata = '1;
      ee_we    = ee_in_range;
      ee_waddr = seq_addr[EE_AW-1:0];
      ee_wdata = '1;
    end else begin
      pm_we    = req_valid_i && req_write_i && !req_ee_i && allow;
      pm_waddr = req_addr_i;
      pm_wdata = req_wdata_i;
      ee_we    = req_valid_i && req_write_i && req_ee_i && allow;
      ee_waddr = req_addr_i[EE_AW-1:0];
      ee_wdata = req_wdata_i[EE_DW-1:0];
    end
  end

  mpg_sram #(.AW(PM_AW), .DW(PM_DW)) pm_i (
    .clk(clk), .we_i(pm_we), .waddr_i(pm_waddr), .wdata_i(pm_wdata),
    .raddr_i(req_addr_i), .rdata_o(pm_q)
  );

  mpg_sram #(.AW(EE_AW), .DW(EE_DW)) ee_i (
    .clk(clk), .we_i(ee_we), .waddr_i(ee_waddr), .wdata_i(ee_wdata),
    .raddr_i(req_addr_i[EE_AW-1:0]), .rdata_o(ee_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      viol_q      <= 1'b0;
      mask_q      <= 1'b1;
      sel_ee_q    <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid_i && !req_write_i;
      viol_q      <= req_valid_i && !allow;
      mask_q      <= !allow;
      sel_ee_q    <= req_ee_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_w1_q  <= shadow_w1_i;
      cfg_w2_q  <= shadow_w2_i;
      pend_w1_q <= shadow_w1_i;
      pend_w2_q <= shadow_w2_i;
    end else begin
      if (erase_req_i && !busy_o) begin
        pend_w1_q <= erase_w1_i;
        pend_w2_q <= erase_w2_i | (lv_entry_i ? LVP_MASK : '0);
      end
      if (seq_done) begin
        cfg_w1_q <= pend_w1_q;
        cfg_w2_q <= pend_w2_q;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign viol_o      = viol_q;
  assign rsp_rdata_o = mask_q ? '0 : (sel_ee_q ? PM_DW'(ee_q) : pm_q);
  assign cfg_w1_o    = cfg_w1_q;
  assign cfg_w2_o    = cfg_w2_q | W2_ONES_MASK;

  AST_CPU_READ_OPEN: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && !req_ext_i && !req_write_i && !busy_o |=> !viol_o); // R2
  AST_REFUSED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o && viol_o |-> rsp_rdata_o == '0); // R3
  AST_VIOL_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    viol_o |-> $past(req_valid_i)); // R6
  AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (rst)
    busy_o && req_valid_i |=> viol_o); // R8
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> $stable(cfg_w1_o) && $stable(cfg_w2_o)); // R9
  AST_UNIMPL_ONES: assert property (@(posedge clk) disable iff (rst)
    (cfg_w2_o & W2_ONES_MASK) == W2_ONES_MASK); // R11
endmodule

// File: tb/prot_access_gate_tb_top.sv
`timescale 1ns/1ps
module prot_access_gate_tb_top;
  localparam int PM_AW = 9;
  localparam int PM_DEPTH = 1 << PM_AW;
  localparam int EE_DEPTH = 64;

  typedef struct {
    bit          rd;
    logic [13:0] data;
    bit          viol;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [13:0] shadow_w1 = 14'h3F7F, shadow_w2 = 14'h2001;
  logic req_valid = 0, req_ext = 0, req_write = 0, req_ee = 0;
  logic [PM_AW-1:0] req_addr = '0;
  logic [13:0] req_wdata = '0;
  logic erase_req = 0, lv_entry = 0;
  logic [13:0] erase_w1 = '0, erase_w2 = '0;
  logic rsp_valid, viol, busy;
  logic [13:0] rsp_rdata, cfg_w1, cfg_w2;

  prot_access_gate dut_i (
    .clk(clk), .rst(rst), .shadow_w1_i(shadow_w1), .shadow_w2_i(shadow_w2),
    .req_valid_i(req_valid), .req_ext_i(req_ext), .req_write_i(req_write),
    .req_ee_i(req_ee), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .erase_req_i(erase_req), .erase_w1_i(erase_w1), .erase_w2_i(erase_w2),
    .lv_entry_i(lv_entry), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .viol_o(viol), .busy_o(busy), .cfg_w1_o(cfg_w1), .cfg_w2_o(cfg_w2)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  exp_t sb[$];
  logic [13:0] pm_m [PM_DEPTH];
  logic [7:0]  ee_m [EE_DEPTH];
  logic [13:0] w1m, w2m;
  bit exp_busy = 0;
  bit pend = 0;
  int bcnt = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic bit allowed(bit ext, bit wr, bit ee, int addr);
    if (exp_busy) return 0;
    if (ee) return !ext || w1m[8];
    if (ext) return w1m[7];
    if (!wr) return 1;
    case (w2m[1:0])
      2'b11:   return 1;
      2'b10:   return addr >= PM_DEPTH / 16;
      2'b01:   return addr >= PM_DEPTH / 2;
      default: return 0;
    endcase
  endfunction

  // driver: decides expected outcome, pushes it, then drives one cycle
  task automatic acc(bit ext, bit wr, bit ee, int addr, logic [13:0] wd, string tag);
    exp_t e;
    bit ok;
    ok = allowed(ext, wr, ee, addr);
    e.rd = !wr;
    e.viol = !ok;
    e.tag = tag;
    e.data = '0;
    if (ok && !wr) e.data = ee ? {6'b0, ee_m[addr]} : pm_m[addr];
    if (ok && wr) begin
      if (ee) ee_m[addr] = wd[7:0];
      else    pm_m[addr] = wd;
    end
    sb.push_back(e);
    req_valid = 1; req_ext = ext; req_write = wr; req_ee = ee;
    req_addr = PM_AW'(addr); req_wdata = wd;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  // monitor: pops the expected item for the request taken at the last edge
  always @(posedge clk) pend <= req_valid && !rst;

  always @(negedge clk) begin
    if (busy) bcnt++;
    if (!rst) begin
      if (pend) begin
        if (sb.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R6: response with empty scoreboard");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " rsp_valid"}, 32'(rsp_valid), 32'(e.rd));
          check({e.tag, " viol"}, 32'(viol), 32'(e.viol));
          if (e.rd) check({e.tag, " rdata"}, 32'(rsp_rdata), 32'(e.data));
        end
      end else if (rsp_valid || viol) begin
        n_chk++; n_bad++;
        $display("FAIL R6: spurious output valid=%0b viol=%0b expected 0", rsp_valid, viol);
      end
    end
  end

  task automatic erase(logic [13:0] w1, logic [13:0] w2, bit lv, bit probe);
    logic [13:0] old1, old2;
    int guard;
    old1 = cfg_w1; old2 = cfg_w2;
    erase_w1 = w1; erase_w2 = w2; lv_entry = lv; erase_req = 1;
    bcnt = 0;
    @(posedge clk); #1;
    erase_req = 0;
    exp_busy = 1;
    check("R7 busy raised", 32'(busy), 1);
    if (probe) begin
      acc(1, 0, 0, 5, 14'h0, "R8 ext read in erase");
      acc(0, 1, 0, 300, 14'h1234, "R8 cpu write in erase");
      acc(0, 0, 1, 3, 14'h0, "R8 cpu ee read in erase");
      check("R9 w1 held", 32'(cfg_w1), 32'(old1));
      check("R9 w2 held", 32'(cfg_w2), 32'(old2));
    end
    guard = 0;
    while (busy && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    @(posedge clk); #1;
    check("R7 busy length", 32'(bcnt), 32'(PM_DEPTH));
    exp_busy = 0;
    for (int i = 0; i < PM_DEPTH; i++) pm_m[i] = 14'h3FFF;
    for (int i = 0; i < EE_DEPTH; i++) ee_m[i] = 8'hFF;
    w1m = w1;
    w2m = w2 | (lv ? 14'h2000 : 14'h0);
    check("R9 w1 installed", 32'(cfg_w1), 32'(w1m));
    check("R10 w2 installed", 32'(cfg_w2), 32'(w2m | 14'h08FC));
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    w1m = shadow_w1; w2m = shadow_w2;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    check("R1 cfg_w1", 32'(cfg_w1), 32'h3F7F);
    check("R11 cfg_w2 ones", 32'(cfg_w2), 32'h28FD);
    check("R1 busy", 32'(busy), 0);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 viol", 32'(viol), 0);
    acc(1, 0, 0, 10, 14'h0, "R1 ext read under shadow CP=0");
    @(posedge clk); #1;

    erase(14'h3FFF, 14'h3FFF, 0, 1);

    // all open, write-protect code 11
    acc(0, 1, 0, 0,     14'h1111, "R5 cpu write code11 low");
    acc(0, 1, 0, 511,   14'h2AAA, "R5 cpu write code11 top");
    acc(0, 0, 0, 0,     14'h0, "R2 cpu read 0");
    acc(0, 0, 0, 511,   14'h0, "R2 cpu read 511");
    acc(1, 1, 0, 16,    14'h0F0F, "R3 ext write CP=1");
    acc(1, 0, 0, 16,    14'h0, "R3 ext read CP=1");
    acc(0, 0, 0, 16,    14'h0, "R2 cpu read ext data");
    acc(1, 1, 1, 5,     14'h00A5, "R4 ext ee write CPD=1");
    acc(1, 0, 1, 5,     14'h0, "R4 ext ee read CPD=1");
    acc(0, 1, 1, 6,     14'h003C, "R4 cpu ee write");
    acc(0, 0, 1, 6,     14'h0, "R4 cpu ee read");
    @(posedge clk); #1;

    // CP=0, CPD=0, write-protect code 10
    erase(14'h3E7F, 14'h3FFE, 0, 0);
    acc(0, 0, 0, 0,   14'h0, "R7 erased pm word");
    acc(0, 0, 1, 5,   14'h0, "R7 erased ee byte");
    acc(1, 0, 0, 0,   14'h0, "R3 ext read CP=0");
    acc(1, 0, 0, 1,   14'h0, "R6 back-to-back refused");
    acc(1, 1, 0, 64,  14'h0001, "R3 ext write CP=0");
    acc(0, 0, 0, 64,  14'h0, "R3 dropped ext write");
    acc(1, 0, 1, 5,   14'h0, "R4 ext ee read CPD=0");
    acc(1, 1, 1, 5,   14'h0011, "R4 ext ee write CPD=0");
    acc(0, 0, 1, 5,   14'h0, "R4 dropped ext ee write");
    acc(0, 1, 1, 7,   14'h0077, "R4 cpu ee write CPD=0");
    acc(0, 0, 1, 7,   14'h0, "R4 cpu ee read CPD=0");
    acc(0, 0, 0, 3,   14'h0, "R2 cpu read CP=0");
    acc(0, 1, 0, 31,  14'h0005, "R5 code10 locked 31");
    acc(0, 0, 0, 31,  14'h0, "R5 code10 read 31");
    acc(0, 1, 0, 32,  14'h0006, "R5 code10 open 32");
    acc(0, 0, 0, 32,  14'h0, "R5 code10 read 32");
    @(posedge clk); #1;

    // write-protect code 01, LVP forced by low-voltage entry
    erase(14'h3FFF, 14'h1001, 1, 0);
    acc(0, 1, 0, 255, 14'h0123, "R5 code01 locked 255");
    acc(0, 1, 0, 256, 14'h0456, "R5 code01 open 256");
    acc(1, 1, 0, 5,   14'h0789, "R5 ext write ignores code01");
    acc(0, 0, 0, 255, 14'h0, "R5 code01 read 255");
    acc(0, 0, 0, 256, 14'h0, "R5 code01 read 256");
    acc(0, 0, 0, 5,   14'h0, "R5 code01 read ext 5");
    @(posedge clk); #1;

    // write-protect code 00, LVP supplied as 0 without low-voltage entry
    erase(14'h3FFF, 14'h0000, 0, 0);
    check("R10 lvp kept 0", 32'(cfg_w2[13]), 0);
    acc(0, 1, 0, 511, 14'h0AAA, "R5 code00 locked 511");
    acc(0, 0, 0, 511, 14'h0, "R5 code00 read 511");
    acc(1, 1, 0, 511, 14'h0BBB, "R5 ext write code00");
    acc(0, 0, 0, 511, 14'h0, "R5 code00 read ext 511");
    repeat (3) @(posedge clk);
    #1;
    check("R6 scoreboard drained", 32'(sb.size()), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule